// File: doc/BRIEF.md
# I2C Status and Interrupt Unit

This block is the status, bus-watch and interrupt section of an I2C controller. It takes the raw SCL and SDA lines through a synchronizer, recognises START and STOP conditions, and counts the nine clocks of each byte. From these events and from strobes given by the neighbouring shifter, address comparator and arbiter, it keeps a one-byte status word that software reads over a simple register bus.

Two status bits, arbitration-lost and the interrupt flag, are cleared by writing 1. A write to the control register clears the addressed-as-slave bit. The interrupt flag raises the CPU interrupt line when interrupt enable is set. When DMA is enabled, completed bytes produce a one-cycle transmit or receive request instead of setting the flag. The request goes out only while the block is configured as master. Arbitration loss and a slave address match still set the flag. A repeated-START command from the control path turns into a one-cycle request to the SCL generator only while the block owns the bus.

Top module: `i2c_status_unit`

## Requirements
- R1: After reset the status word reads 0x80 (only transfer-complete set), and `irq`, `dma_tx_req`, `dma_rx_req` and `rsta_req` are 0.
- R2: The status word layout, from bit 7 down to bit 0, is: transfer-complete, addressed-as-slave, bus-busy, arbitration-lost, reserved (always 0), slave read/write, interrupt flag, received-acknowledge.
- R3: Transfer-complete (bit 7) clears on the first SCL rising edge of a byte and sets on the falling SCL edge of the ninth clock of that byte.
- R4: Bus-busy (bit 5) sets on a START (SDA falls while SCL is high) and clears on a STOP (SDA rises while SCL is high). A repeated START keeps it set.
- R5: An address-match strobe sets addressed-as-slave (bit 6) and loads the R/W input into slave read/write (bit 2). Any control-register write strobe clears bit 6.
- R6: Received-acknowledge (bit 0) takes the SDA level at the rising SCL edge of the ninth clock.
- R7: Writing 1 to bit 4 clears arbitration-lost, and writing 1 to bit 1 clears the interrupt flag. Writing 0 to them, and writing anything to the other bits, changes nothing.
- R8: The interrupt flag sets on arbitration loss, on an address match, and, with DMA disabled, on byte completion. `irq` equals the flag ANDed with interrupt enable.
- R9: With DMA enabled, byte completion leaves the interrupt flag unchanged. If the block is master, it gives a one-cycle `dma_tx_req` (transmit mode) or `dma_rx_req` (receive mode) in the cycle after the ninth falling SCL edge is seen. Otherwise it gives no request.
- R10: With DMA enabled, arbitration loss and address match still set the interrupt flag.
- R11: A control write with the repeated-START bit set gives a one-cycle `rsta_req` only when the block is master and the bus is busy. Otherwise it gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line |
| sda_in | input | 1 | Raw SDA line |
| match_stb | input | 1 | Own address matched the calling address |
| rw_bit | input | 1 | R/W bit of the matched address byte |
| arb_lost_stb | input | 1 | Arbitration lost |
| ctl_ien | input | 1 | Interrupt enable |
| ctl_dma | input | 1 | DMA enable |
| ctl_master | input | 1 | Block is configured as master |
| ctl_tx | input | 1 | Transmit mode (1) or receive mode (0) |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_rsta | input | 1 | Repeated-START bit of the control write data |
| st_wr | input | 1 | Status register write strobe |
| st_wdata | input | 8 | Status write data (1 clears the W1C bits) |
| status | output | 8 | Status word |
| irq | output | 1 | CPU interrupt |
| dma_tx_req | output | 1 | DMA transmit request pulse |
| dma_rx_req | output | 1 | DMA receive request pulse |
| rsta_req | output | 1 | Repeated-START request pulse |

## Verification
The hardest cases to reach are the ones in the middle of a byte: the transfer-complete bit has to be seen low right after the first SCL rise, and the ninth-clock SDA sample has to be seen alone. The bench reaches them by driving a real bit-level bus waveform, with each line phase held long enough to pass the synchronizer, and by checking the status word between phases. A scoreboard queue holds one expected DMA or repeated-START pulse per expected event. A monitor pops the queue on each pulse, so pulses that are missing, extra or of the wrong kind are all caught, including under non-master and idle-bus conditions.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    // Status word, bit 7 first
    typedef struct packed {
        logic tcf;
        logic iaas;
        logic busy;
        logic arbl;
        logic rsvd;
        logic srw;
        logic iflag;
        logic rxak;
    } stat_t;

    // Bus events from the line monitor, one cycle each
    typedef struct packed {
        logic start;
        logic stop;
        logic byte_beg;
        logic ack_smp;
        logic ack_val;
        logic byte_done;
    } bus_ev_t;

    localparam int ARBL_BIT  = 4;
    localparam int IFLAG_BIT = 1;

    localparam stat_t STAT_RESET = '{tcf: 1'b1, default: 1'b0};

    function automatic logic w1c_hit(input logic wr, input logic [7:0] data, input int pos);
        return wr && data[pos];
    endfunction

endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon
    import i2c_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_CLKS   = 9
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev,
    output logic    scl_s
);
    localparam int CW = $clog2(BYTE_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(BYTE_CLKS);
    localparam logic [CW-1:0] PREV = CW'(BYTE_CLKS - 1);

    logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
    logic scl_d, sda_d, sda_s;
    logic scl_rise, scl_fall, sda_rise, sda_fall;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_in};
            sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_in};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    assign scl_s = scl_sr[SYNC_STAGES-1];
    assign sda_s = sda_sr[SYNC_STAGES-1];

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign sda_rise = sda_s & ~sda_d;
    assign sda_fall = ~sda_s & sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ev.start || ev.stop) begin
            cnt <= '0;
        end else if (scl_rise && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end else if (scl_fall && cnt == LAST) begin
            cnt <= '0;
        end
    end

    always_comb begin
        ev.start     = sda_fall & scl_s & scl_d;
        ev.stop      = sda_rise & scl_s & scl_d;
        ev.byte_beg  = scl_rise && cnt == '0;
        ev.ack_smp   = scl_rise && cnt == PREV;
        ev.ack_val   = sda_s;
        ev.byte_done = scl_fall && cnt == LAST;
    end

    assert_cnt_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        ev.byte_done |=> cnt == '0);

endmodule

// File: rtl/i2c_stat_regs.sv
module i2c_stat_regs
    import i2c_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic       match_stb,
    input  logic       rw_bit,
    input  logic       arb_lost_stb,
    input  logic       ctl_wr,
    input  logic       dma_en,
    input  logic       st_wr,
    input  logic [7:0] st_wdata,
    output stat_t      st
);
    logic arb_clr, if_clr, if_set;

    assign arb_clr = w1c_hit(st_wr, st_wdata, ARBL_BIT);
    assign if_clr  = w1c_hit(st_wr, st_wdata, IFLAG_BIT);
    assign if_set  = (ev.byte_done && !dma_en) || arb_lost_stb || match_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= STAT_RESET;
        end else begin
            // transfer complete
            if (ev.byte_done)     st.tcf <= 1'b1;
            else if (ev.byte_beg) st.tcf <= 1'b0;
            // addressed as slave and its R/W bit
            if (match_stb) begin
                st.iaas <= 1'b1;
                st.srw  <= rw_bit;
            end else if (ctl_wr) begin
                st.iaas <= 1'b0;
            end
            // bus busy
            if (ev.start)     st.busy <= 1'b1;
            else if (ev.stop) st.busy <= 1'b0;
            // arbitration lost
            if (arb_lost_stb) st.arbl <= 1'b1;
            else if (arb_clr) st.arbl <= 1'b0;
            // interrupt flag
            if (if_set)      st.iflag <= 1'b1;
            else if (if_clr) st.iflag <= 1'b0;
            // acknowledge sample
            if (ev.ack_smp) st.rxak <= ev.ack_val;
            st.rsvd <= 1'b0;
        end
    end

    assert_tcf_set_R3: assert property (@(posedge clk) disable iff (rst)
        ev.byte_done |=> st.tcf);
    assert_busy_set_R4: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> st.busy);
    assert_busy_clr_R4: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !ev.start) |=> !st.busy);
    assert_arb_w1c_R7: assert property (@(posedge clk) disable iff (rst)
        (st_wr && st_wdata[ARBL_BIT] && !arb_lost_stb) |=> !st.arbl);
    assert_dma_noflag_R9: assert property (@(posedge clk) disable iff (rst)
        (dma_en && !st.iflag && !match_stb && !arb_lost_stb) |=> !st.iflag);
    assert_iaas_clr_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !match_stb) |=> !st.iaas);

endmodule

// File: rtl/i2c_irq_dma.sv
module i2c_irq_dma (
    input  logic clk,
    input  logic rst,
    input  logic byte_done,
    input  logic dma_en,
    input  logic master,
    input  logic tx_mode,
    input  logic iflag,
    input  logic ien,
    input  logic busy,
    input  logic ctl_wr,
    input  logic ctl_rsta,
    output logic irq,
    output logic dma_tx_req,
    output logic dma_rx_req,
    output logic rsta_req
);
    logic dma_fire;

    assign dma_fire = byte_done && dma_en && master;
    assign irq      = iflag & ien;

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_tx_req <= 1'b0;
            dma_rx_req <= 1'b0;
            rsta_req   <= 1'b0;
        end else begin
            dma_tx_req <= dma_fire && tx_mode;
            dma_rx_req <= dma_fire && !tx_mode;
            rsta_req   <= ctl_wr && ctl_rsta && master && busy;
        end
    end

    assert_dma_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dma_tx_req, dma_rx_req}));
    assert_dma_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (dma_tx_req || dma_rx_req) |=> !(dma_tx_req || dma_rx_req));
    assert_rsta_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rsta_req |=> !rsta_req);
    assert_rsta_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !busy) |=> !rsta_req);

endmodule

// File: rtl/i2c_status_unit.sv
module i2c_status_unit
    import i2c_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_CLKS   = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       match_stb,
    input  logic       rw_bit,
    input  logic       arb_lost_stb,
    input  logic       ctl_ien,
    input  logic       ctl_dma,
    input  logic       ctl_master,
    input  logic       ctl_tx,
    input  logic       ctl_wr,
    input  logic       ctl_rsta,
    input  logic       st_wr,
    input  logic [7:0] st_wdata,
    output logic [7:0] status,
    output logic       irq,
    output logic       dma_tx_req,
    output logic       dma_rx_req,
    output logic       rsta_req
);
    bus_ev_t ev;
    stat_t   st;
    logic    scl_s;

    i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES), .BYTE_CLKS(BYTE_CLKS)) u_mon (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .ev(ev), .scl_s(scl_s)
    );

    i2c_stat_regs u_regs (
        .clk(clk), .rst(rst), .ev(ev), .match_stb(match_stb), .rw_bit(rw_bit),
        .arb_lost_stb(arb_lost_stb), .ctl_wr(ctl_wr), .dma_en(ctl_dma),
        .st_wr(st_wr), .st_wdata(st_wdata), .st(st)
    );

    i2c_irq_dma u_irq (
        .clk(clk), .rst(rst), .byte_done(ev.byte_done), .dma_en(ctl_dma),
        .master(ctl_master), .tx_mode(ctl_tx), .iflag(st.iflag), .ien(ctl_ien),
        .busy(st.busy), .ctl_wr(ctl_wr), .ctl_rsta(ctl_rsta), .irq(irq),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .rsta_req(rsta_req)
    );

    assign status = st;

    // R2: reserved bit never set; checked against the line-monitor view of SCL
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        scl_s |-> status[3] == 1'b0);
    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
        !ctl_ien |-> !irq);

endmodule

// File: tb/tb_i2c_status_unit.sv
module tb_i2c_status_unit;
    localparam int CLK_P = 10;
    localparam int PH    = 4;

    logic clk = 0, rst = 1;
    logic scl_in = 1, sda_in = 1, match_stb = 0, rw_bit = 0, arb_lost_stb = 0;
    logic ctl_ien = 1, ctl_dma = 0, ctl_master = 0, ctl_tx = 0, ctl_wr = 0, ctl_rsta = 0;
    logic st_wr = 0;
    logic [7:0] st_wdata = 0;
    logic [7:0] status;
    logic irq, dma_tx_req, dma_rx_req, rsta_req;

    int total = 0, bad = 0;
    int exp_q[$];   // 1 = tx, 2 = rx, 3 = rsta

    always #(CLK_P/2) clk = ~clk;

    i2c_status_unit dut (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .match_stb(match_stb), .rw_bit(rw_bit), .arb_lost_stb(arb_lost_stb),
        .ctl_ien(ctl_ien), .ctl_dma(ctl_dma), .ctl_master(ctl_master),
        .ctl_tx(ctl_tx), .ctl_wr(ctl_wr), .ctl_rsta(ctl_rsta),
        .st_wr(st_wr), .st_wdata(st_wdata), .status(status), .irq(irq),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .rsta_req(rsta_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && (dma_tx_req || dma_rx_req || rsta_req)) begin
            int kind;
            kind = dma_tx_req ? 1 : (dma_rx_req ? 2 : 3);
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R9/R11: actual pulse=%0d expected=none", kind);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != kind) begin
                    bad++;
                    $display("FAIL R9/R11: actual pulse=%0d expected=%0d", kind, e);
                end
            end
        end
    end

    task automatic wt(); repeat (PH) @(negedge clk); endtask

    task automatic pulse(ref logic s);
        s = 1; @(negedge clk); s = 0; wt();
    endtask

    task automatic sw(input logic [7:0] d);
        st_wdata = d; st_wr = 1; @(negedge clk); st_wr = 0; st_wdata = 0; wt();
    endtask

    task automatic bus_start();
        sda_in = 1; wt(); scl_in = 1; wt(); sda_in = 0; wt(); scl_in = 0; wt();
    endtask

    task automatic bus_stop();
        sda_in = 0; wt(); scl_in = 1; wt(); sda_in = 1; wt();
    endtask

    task automatic send_byte(input logic [7:0] d, input logic ack);
        for (int i = 0; i < 9; i++) begin
            sda_in = (i < 8) ? d[7-i] : ack; wt();
            scl_in = 1; wt();
            if (i == 0) chk("R3 tcf clears", status[7], 0);
            scl_in = 0; wt();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0; @(negedge clk);
        chk("R1 reset status", status, 8'h80);
        chk("R1 reset irq", {irq, dma_tx_req, dma_rx_req, rsta_req}, 0);

        bus_start();
        chk("R4 busy on start", status, 8'hA0);
        send_byte(8'hA5, 1'b0);
        chk("R3 R8 byte done", status, 8'hA2);
        chk("R8 irq", irq, 1);

        sw(8'hFF);
        chk("R7 w1c iflag only", status, 8'hA0);

        rw_bit = 1; pulse(match_stb); rw_bit = 0;
        chk("R5 match", status, 8'hE6);
        pulse(ctl_wr);
        chk("R5 ctl write clears iaas", status, 8'hA6);
        sw(8'h00);
        chk("R7 zero write ignored", status, 8'hA6);
        sw(8'h02);

        pulse(arb_lost_stb);
        chk("R8 arb lost", status, 8'hB6);
        sw(8'h10);
        chk("R7 clear arb only", status, 8'hA6);
        sw(8'h02);

        ctl_ien = 0;
        pulse(match_stb);
        chk("R8 irq gated", {status[1], irq}, 2'b10);
        pulse(ctl_wr); sw(8'h02); ctl_ien = 1;
        chk("R5 R7 cleared", status, 8'hA0);

        ctl_dma = 1; ctl_master = 1; ctl_tx = 1;
        exp_q.push_back(1);
        send_byte(8'h3C, 1'b1);
        chk("R6 R9 dma tx byte", status, 8'hA1);
        ctl_tx = 0;
        exp_q.push_back(2);
        send_byte(8'hC3, 1'b0);
        chk("R6 R9 dma rx byte", status, 8'hA0);
        pulse(arb_lost_stb);
        chk("R10 arb in dma", {status[4], status[1], irq}, 3'b111);
        sw(8'h12);
        ctl_master = 0;
        send_byte(8'h55, 1'b1);
        chk("R9 no req as slave", status, 8'hA1);

        ctl_master = 1; ctl_rsta = 1;
        exp_q.push_back(3);
        pulse(ctl_wr);
        ctl_master = 0;
        pulse(ctl_wr);
        ctl_rsta = 0; ctl_master = 1;
        bus_start();
        chk("R4 repeated start keeps busy", status[5], 1);
        bus_stop();
        chk("R4 stop clears busy", status[5], 0);
        ctl_rsta = 1; pulse(ctl_wr); ctl_rsta = 0;
        wt();
        chk("R9 R11 scoreboard drained", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule